// File: doc/BRIEF.md
# Pseudo-Associative Cache Lookup

This block controls lookup and refill for a small direct-mapped line array that acts like a two-way cache when it misses. A read request names a word address. The low bits of the address select a home line. If the home line does not hold the word, the controller probes a partner line on the next cycle. The partner index is the home index with its top bit inverted. A match on the partner line is reported as a pseudo-hit, and the two lines are exchanged so that the next access to the same word hits at home. If neither line holds the word, the controller asks lower memory for it over a level-held request. It installs the returned word at home and moves the displaced home line into the partner slot.

The block is meant to sit between a requester that can wait and a single-word memory port. The requester may present a request only while `busy` is low. Any request presented while `busy` is high is ignored. Each stored line holds a valid bit, the tag, and the top index bit of the line's own home slot. A line parked in its partner slot is therefore never mistaken for a different word whose home is that slot.

Top module: `pac_cache_lookup`

## Requirements
- R1: Reset clears every line. Right after reset `busy`, `rsp_valid` and `fill_req_valid` are low, and the first access to any address is a miss. A fill cut short by reset leaves nothing behind.
- R2: The home index is `req_addr[IDX_W-1:0]` and the tag is the address bits above it. When the home line holds the word, `rsp_valid` rises in the cycle after the accepting edge with `rsp_kind` = 2'b01 and the stored word, and no fill is requested.
- R3: When the home line misses and the partner line (home index with its top bit inverted) holds the word, the response comes two cycles after the accepting edge with `rsp_kind` = 2'b10 and the stored word. No fill is requested.
- R4: A pseudo-hit exchanges the home and partner lines. The next access to the same word is a home hit, and the word that was at home becomes a pseudo-hit.
- R5: When both probes miss, `fill_req_valid` rises two cycles after the accepting edge. `fill_req_addr` equals the request address and stays stable until `fill_rsp_valid` is sampled high. The response (`rsp_kind` = 2'b11, data = `fill_rsp_data`) comes in the cycle after that sample. `rsp_valid` is a single-cycle pulse.
- R6: On a fill, the new word is placed at its home line. The previous home occupant moves to the partner line and becomes a pseudo-hit. The previous partner occupant is evicted and misses.
- R7: `busy` is high in every cycle after a non-hit acceptance until the response cycle, and low in the response cycle. A request presented while `busy` is high gets no response and causes no fill, and its word is not installed.
- R8: A line resident in its partner slot does not give a home hit to an address whose home is that slot, even when the tag bits are equal. Such an access misses.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Read request, taken when `busy` is low |
| req_addr | input | ADDR_W | Word address of the request |
| busy | output | 1 | Controller is in a partner probe or a fill |
| rsp_valid | output | 1 | One-cycle response strobe |
| rsp_kind | output | 2 | 01 home hit, 10 pseudo-hit, 11 miss |
| rsp_data | output | DATA_W | Word returned with the response |
| fill_req_valid | output | 1 | Fill request to lower memory, held until answered |
| fill_req_addr | output | ADDR_W | Word address being fetched |
| fill_rsp_valid | input | 1 | Lower memory returns the word this cycle |
| fill_rsp_data | input | DATA_W | Word returned by lower memory |

## Verification
Several internal faults show up at the ports within one access:
- A wrong home or partner index, or a missing home-bit comparison, turns an expected hit or pseudo-hit into a different `rsp_kind` on the very next response.
- A broken exchange or refill placement corrupts the array silently. It appears only on the next access to the displaced word, as a kind that differs from the one the replacement rules predict.
- A control fault shows up as wrong response latency, a `busy` level that drops early, or a fill request that appears on a hit or whose address moves.

The stimulus is therefore a sequence in which each access's expected kind depends on the exchanges and evictions made before it.

// File: rtl/pac_pkg.sv
`timescale 1ns/1ps
package pac_pkg;
  typedef enum logic [1:0] {
    PS_IDLE = 2'd0,
    PS_ALT  = 2'd1,
    PS_FILL = 2'd2
  } pac_state_e;

  localparam logic [1:0] KIND_HIT    = 2'b01;
  localparam logic [1:0] KIND_PSEUDO = 2'b10;
  localparam logic [1:0] KIND_MISS   = 2'b11;
endpackage

// File: rtl/pac_line_store.sv
`timescale 1ns/1ps
module pac_line_store #(
  parameter int LINES  = 8,
  parameter int IDX_W  = 3,
  parameter int LINE_W = 27
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [IDX_W-1:0]  rd_a_idx,
  input  logic [IDX_W-1:0]  rd_b_idx,
  output logic [LINE_W-1:0] rd_a_line,
  output logic [LINE_W-1:0] rd_b_line,
  input  logic              wr_a_en,
  input  logic [IDX_W-1:0]  wr_a_idx,
  input  logic [LINE_W-1:0] wr_a_line,
  input  logic              wr_b_en,
  input  logic [IDX_W-1:0]  wr_b_idx,
  input  logic [LINE_W-1:0] wr_b_line
);
  logic [LINE_W-1:0] lines_q [LINES];

  // Two independent write ports; the controller never aims them at one line.
  always_ff @(posedge clk) begin
    for (int i = 0; i < LINES; i++) begin
      if (!rst_n) begin
        lines_q[i] <= '0;
      end else if (wr_a_en && (wr_a_idx == IDX_W'(i))) begin
        lines_q[i] <= wr_a_line;
      end else if (wr_b_en && (wr_b_idx == IDX_W'(i))) begin
        lines_q[i] <= wr_b_line;
      end
    end
  end

  assign rd_a_line = lines_q[rd_a_idx];
  assign rd_b_line = lines_q[rd_b_idx];
endmodule

// File: rtl/pac_probe.sv
`timescale 1ns/1ps
module pac_probe #(
  parameter int TAG_W  = 9,
  parameter int DATA_W = 16,
  parameter int LINE_W = 27
) (
  input  logic [LINE_W-1:0] line,
  input  logic [TAG_W-1:0]  look_tag,
  input  logic              look_msb,
  output logic              match,
  output logic [DATA_W-1:0] data
);
  // Line layout: valid | home top index bit | tag | data
  logic             valid;
  logic             home_msb;
  logic [TAG_W-1:0] tag;

  assign valid    = line[LINE_W-1];
  assign home_msb = line[LINE_W-2];
  assign tag      = line[DATA_W +: TAG_W];
  assign data     = line[DATA_W-1:0];
  assign match    = valid && (home_msb == look_msb) && (tag == look_tag);
endmodule

// File: rtl/pac_ctrl.sv
`timescale 1ns/1ps
module pac_ctrl
  import pac_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic req_valid,
  input  logic home_match,
  input  logic alt_match,
  input  logic fill_rsp_valid,
  output logic idle,
  output logic capture,
  output logic ev_hit,
  output logic ev_pseudo,
  output logic ev_fill_done,
  output logic fill_active
);
  pac_state_e state_q, state_d;

  assign idle         = (state_q == PS_IDLE);
  assign fill_active  = (state_q == PS_FILL);
  assign ev_hit       = idle && req_valid && home_match;
  assign capture      = idle && req_valid && !home_match;
  assign ev_pseudo    = (state_q == PS_ALT) && alt_match;
  assign ev_fill_done = fill_active && fill_rsp_valid;

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      PS_IDLE: if (capture) state_d = PS_ALT;
      PS_ALT:  state_d = alt_match ? PS_IDLE : PS_FILL;
      PS_FILL: if (fill_rsp_valid) state_d = PS_IDLE;
      default: state_d = PS_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) state_q <= PS_IDLE;
    else        state_q <= state_d;
  end
endmodule

// File: rtl/pac_cache_lookup.sv
`timescale 1ns/1ps
module pac_cache_lookup
  import pac_pkg::*;
#(
  parameter int ADDR_W = 12,
  parameter int LINES  = 8,
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic [ADDR_W-1:0] req_addr,
  output logic              busy,
  output logic              rsp_valid,
  output logic [1:0]        rsp_kind,
  output logic [DATA_W-1:0] rsp_data,
  output logic              fill_req_valid,
  output logic [ADDR_W-1:0] fill_req_addr,
  input  logic              fill_rsp_valid,
  input  logic [DATA_W-1:0] fill_rsp_data
);
  localparam int IDX_W  = $clog2(LINES);
  localparam int TAG_W  = ADDR_W - IDX_W;
  localparam int LINE_W = 2 + TAG_W + DATA_W;
  localparam logic [IDX_W-1:0] FLIP = {1'b1, {(IDX_W-1){1'b0}}};

  function automatic logic [IDX_W-1:0] home_idx(input logic [ADDR_W-1:0] a);
    return a[IDX_W-1:0];
  endfunction

  function automatic logic [IDX_W-1:0] alt_idx(input logic [IDX_W-1:0] h);
    return h ^ FLIP;
  endfunction

  function automatic logic [TAG_W-1:0] addr_tag(input logic [ADDR_W-1:0] a);
    return a[ADDR_W-1:IDX_W];
  endfunction

  function automatic logic [LINE_W-1:0] make_line(input logic [ADDR_W-1:0] a,
                                                  input logic [DATA_W-1:0] d);
    return {1'b1, a[IDX_W-1], addr_tag(a), d};
  endfunction

  // Control events, brought out for the checker
  logic idle, capture, ev_hit, ev_pseudo, ev_fill_done, fill_active;
  logic home_match, alt_match;

  logic [ADDR_W-1:0] addr_q;
  logic [ADDR_W-1:0] look_addr;
  logic [IDX_W-1:0]  look_home, look_alt;

  logic [LINE_W-1:0] rd_a_line, rd_b_line;
  logic              wr_a_en, wr_b_en;
  logic [IDX_W-1:0]  wr_a_idx, wr_b_idx;
  logic [LINE_W-1:0] wr_a_line, wr_b_line;

  logic [LINE_W-1:0] probe_line  [2];
  logic              probe_hit   [2];
  logic [DATA_W-1:0] probe_data  [2];

  assign look_addr = idle ? req_addr : addr_q;
  assign look_home = home_idx(look_addr);
  assign look_alt  = alt_idx(look_home);

  pac_ctrl u_ctrl (
    .clk            (clk),
    .rst_n          (rst_n),
    .req_valid      (req_valid),
    .home_match     (home_match),
    .alt_match      (alt_match),
    .fill_rsp_valid (fill_rsp_valid),
    .idle           (idle),
    .capture        (capture),
    .ev_hit         (ev_hit),
    .ev_pseudo      (ev_pseudo),
    .ev_fill_done   (ev_fill_done),
    .fill_active    (fill_active)
  );

  pac_line_store #(.LINES(LINES), .IDX_W(IDX_W), .LINE_W(LINE_W)) u_store (
    .clk       (clk),
    .rst_n     (rst_n),
    .rd_a_idx  (look_home),
    .rd_b_idx  (look_alt),
    .rd_a_line (rd_a_line),
    .rd_b_line (rd_b_line),
    .wr_a_en   (wr_a_en),
    .wr_a_idx  (wr_a_idx),
    .wr_a_line (wr_a_line),
    .wr_b_en   (wr_b_en),
    .wr_b_idx  (wr_b_idx),
    .wr_b_line (wr_b_line)
  );

  assign probe_line[0] = rd_a_line;
  assign probe_line[1] = rd_b_line;

  // Slot 0 probes the home line, slot 1 the partner line
  for (genvar p = 0; p < 2; p++) begin : g_probe
    pac_probe #(.TAG_W(TAG_W), .DATA_W(DATA_W), .LINE_W(LINE_W)) u_probe (
      .line     (probe_line[p]),
      .look_tag (addr_tag(look_addr)),
      .look_msb (look_addr[IDX_W-1]),
      .match    (probe_hit[p]),
      .data     (probe_data[p])
    );
  end

  assign home_match = probe_hit[0];
  assign alt_match  = probe_hit[1];

  // Exchange on pseudo-hit, install-and-demote on fill
  assign wr_a_en   = ev_pseudo || ev_fill_done;
  assign wr_b_en   = ev_pseudo || ev_fill_done;
  assign wr_a_idx  = look_home;
  assign wr_b_idx  = look_alt;
  assign wr_a_line = ev_pseudo ? rd_b_line : make_line(addr_q, fill_rsp_data);
  assign wr_b_line = rd_a_line;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      addr_q <= '0;
    end else if (capture) begin
      addr_q <= req_addr;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rsp_valid <= 1'b0;
      rsp_kind  <= 2'b00;
      rsp_data  <= '0;
    end else begin
      rsp_valid <= ev_hit || ev_pseudo || ev_fill_done;
      if (ev_hit) begin
        rsp_kind <= KIND_HIT;
        rsp_data <= probe_data[0];
      end else if (ev_pseudo) begin
        rsp_kind <= KIND_PSEUDO;
        rsp_data <= probe_data[1];
      end else if (ev_fill_done) begin
        rsp_kind <= KIND_MISS;
        rsp_data <= fill_rsp_data;
      end
    end
  end

  assign busy           = !idle;
  assign fill_req_valid = fill_active;
  assign fill_req_addr  = addr_q;
endmodule

// File: rtl/pac_cache_lookup_checker.sv
`timescale 1ns/1ps
module pac_cache_lookup_checker #(
  parameter int ADDR_W = 12,
  parameter int IDX_W  = 3
) (
  input logic              clk,
  input logic              rst_n,
  input logic              req_valid,
  input logic              busy,
  input logic              rsp_valid,
  input logic [1:0]        rsp_kind,
  input logic              fill_req_valid,
  input logic [ADDR_W-1:0] fill_req_addr,
  input logic              fill_rsp_valid,
  input logic              ev_pseudo,
  input logic              wr_a_en,
  input logic              wr_b_en,
  input logic [IDX_W-1:0]  wr_a_idx,
  input logic [IDX_W-1:0]  wr_b_idx
);
  localparam logic [IDX_W-1:0] FLIP = {1'b1, {(IDX_W-1){1'b0}}};

  assert_reset_quiet_R1: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> (!busy && !rsp_valid && !fill_req_valid));

  assert_hit_after_accept_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && rsp_kind == 2'b01) |-> $past(req_valid && !busy));

  assert_pseudo_responds_R3: assert property (@(posedge clk) disable iff (!rst_n)
    ev_pseudo |=> (rsp_valid && rsp_kind == 2'b10));

  assert_miss_after_fill_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && rsp_kind == 2'b11) |-> $past(fill_req_valid && fill_rsp_valid));

  assert_fill_addr_stable_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (fill_req_valid && !fill_rsp_valid) |=> (fill_req_valid && $stable(fill_req_addr)));

  assert_pair_writes_partner_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_a_en && wr_b_en) |-> ((wr_a_idx ^ wr_b_idx) == FLIP));

  assert_fill_only_busy_R7: assert property (@(posedge clk) disable iff (!rst_n)
    fill_req_valid |-> busy);

  assert_idle_at_response_R7: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> !busy);
endmodule

bind pac_cache_lookup pac_cache_lookup_checker #(.ADDR_W(ADDR_W), .IDX_W(IDX_W)) u_chk (
  .clk            (clk),
  .rst_n          (rst_n),
  .req_valid      (req_valid),
  .busy           (busy),
  .rsp_valid      (rsp_valid),
  .rsp_kind       (rsp_kind),
  .fill_req_valid (fill_req_valid),
  .fill_req_addr  (fill_req_addr),
  .fill_rsp_valid (fill_rsp_valid),
  .ev_pseudo      (ev_pseudo),
  .wr_a_en        (wr_a_en),
  .wr_b_en        (wr_b_en),
  .wr_a_idx       (wr_a_idx),
  .wr_b_idx       (wr_b_idx)
);

// File: tb/pac_cache_lookup_test.sv
`timescale 1ns/1ps
module pac_cache_lookup_test;
  localparam int ADDR_W = 12;
  localparam int DATA_W = 16;
  localparam logic [1:0] K_H = 2'b01;
  localparam logic [1:0] K_P = 2'b10;
  localparam logic [1:0] K_M = 2'b11;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic              req_valid = 1'b0;
  logic [ADDR_W-1:0] req_addr = '0;
  logic              busy, rsp_valid, fill_req_valid;
  logic [1:0]        rsp_kind;
  logic [DATA_W-1:0] rsp_data;
  logic [ADDR_W-1:0] fill_req_addr;
  logic              fill_rsp_valid = 1'b0;
  logic [DATA_W-1:0] fill_rsp_data = '0;

  int checks = 0;
  int errors = 0;
  bit finished = 1'b0;

  always #2.5 clk = ~clk;

  pac_cache_lookup #(.ADDR_W(ADDR_W), .LINES(8), .DATA_W(DATA_W)) uut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_addr(req_addr),
    .busy(busy), .rsp_valid(rsp_valid), .rsp_kind(rsp_kind), .rsp_data(rsp_data),
    .fill_req_valid(fill_req_valid), .fill_req_addr(fill_req_addr),
    .fill_rsp_valid(fill_rsp_valid), .fill_rsp_data(fill_rsp_data)
  );

  function automatic logic [DATA_W-1:0] mem_word(input logic [ADDR_W-1:0] a);
    return {a[3:0], a} ^ 16'h5A3C;
  endfunction

  task automatic chk(input bit ok, input string rq, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h", rq, what, act, exp);
    end
  endtask

  // Vector: {address, expected kind, fill delay}; 8 lines, index = addr[2:0]
  localparam int NV = 24;
  localparam logic [15:0] VEC [NV] = '{
    {12'h010, K_M, 2'd0},
    {12'h010, K_H, 2'd0},
    {12'h020, K_M, 2'd1},
    {12'h010, K_P, 2'd0},  // R4: exchange with 020
    {12'h010, K_H, 2'd0},  // R4: now at home
    {12'h020, K_P, 2'd0},  // R4: displaced word at partner
    {12'h030, K_M, 2'd2},  // R6: 020 demoted, 010 evicted
    {12'h010, K_M, 2'd3},  // R6: evicted word misses
    {12'h030, K_P, 2'd0},  // R6: demoted home occupant
    {12'h020, K_M, 2'd0},  // R6
    {12'h015, K_M, 2'd1},
    {12'h015, K_H, 2'd0},
    {12'h0A7, K_M, 2'd0},
    {12'h0A7, K_H, 2'd0},
    {12'h015, K_H, 2'd0},
    {12'h020, K_H, 2'd0},
    {12'h030, K_P, 2'd0},
    {12'h020, K_P, 2'd0},
    {12'h046, K_M, 2'd1},
    {12'h056, K_M, 2'd0},  // 046 parked in slot 2
    {12'h042, K_M, 2'd2},  // R8: same tag as 046 in slot 2, must miss
    {12'h046, K_H, 2'd0},  // R8: back at its home
    {12'h01D, K_M, 2'd0},
    {12'h015, K_P, 2'd0}   // R3: partner of slot 5 is slot 1
  };

  task automatic access(input logic [ADDR_W-1:0] a, input logic [1:0] k, input int dly,
                        input bit ham, input logic [ADDR_W-1:0] ha);
    int cyc, fw, lat;
    bit busy_bad, addr_bad, fill_seen;
    string tg;
    tg = (k == K_H) ? "R2" : (k == K_P) ? "R3" : "R5";
    @(negedge clk);
    req_valid = 1'b1;
    req_addr  = a;
    @(negedge clk);
    if (ham) req_addr = ha;
    else     req_valid = 1'b0;
    cyc = 1; fw = 0; busy_bad = 0; addr_bad = 0; fill_seen = 0;
    while (!rsp_valid && cyc < 64) begin
      if (!busy) busy_bad = 1;
      if (fill_req_valid) begin
        fill_seen = 1;
        if (fill_req_addr !== a) addr_bad = 1;
        if (fw == dly) begin
          fill_rsp_valid = 1'b1;
          fill_rsp_data  = mem_word(a);
        end
        fw++;
      end
      @(negedge clk);
      fill_rsp_valid = 1'b0;
      cyc++;
    end
    req_valid = 1'b0;
    lat = (k == K_H) ? 1 : (k == K_P) ? 2 : 3 + dly;
    chk(rsp_valid === 1'b1, tg, "response seen", 32'(rsp_valid), 1);
    chk(rsp_kind === k, tg, "kind", 32'(rsp_kind), 32'(k));
    chk(rsp_data === mem_word(a), tg, "data", 32'(rsp_data), 32'(mem_word(a)));
    chk(cyc == lat, tg, "latency", 32'(cyc), 32'(lat));
    chk(fill_seen == (k == K_M), "R5", "fill requested", 32'(fill_seen), 32'(k == K_M));
    chk(!addr_bad, "R5", "fill address", 32'(addr_bad), 0);
    chk(!busy_bad, "R7", "busy while pending", 32'(busy_bad), 0);
    chk(busy === 1'b0, "R7", "busy at response", 32'(busy), 0);
    @(negedge clk);
    chk(rsp_valid === 1'b0, "R5", "response pulse width", 32'(rsp_valid), 0);
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    req_valid = 1'b0;
    fill_rsp_valid = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
  endtask

  initial begin : watchdog
    repeat (20000) @(posedge clk);
    if (!finished) begin
      errors++;
      checks++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin : main
    do_reset();
    @(negedge clk);
    chk(busy === 1'b0, "R1", "busy after reset", 32'(busy), 0);
    chk(rsp_valid === 1'b0, "R1", "rsp_valid after reset", 32'(rsp_valid), 0);
    chk(fill_req_valid === 1'b0, "R1", "fill after reset", 32'(fill_req_valid), 0);

    for (int i = 0; i < NV; i++) begin
      access(VEC[i][15:4], VEC[i][3:2], int'(VEC[i][1:0]), 1'b0, '0);
    end

    // R7: requests held during a miss are ignored and leave nothing installed
    access(12'h0F0, K_M, 2, 1'b1, 12'h0E8);
    access(12'h0E8, K_M, 0, 1'b0, '0);

    // R1: reset in the middle of a fill
    do_reset();
    @(negedge clk);
    req_valid = 1'b1;
    req_addr  = 12'h0A7;
    @(negedge clk);
    req_valid = 1'b0;
    @(negedge clk);
    chk(fill_req_valid === 1'b1, "R5", "fill raised two cycles after accept", 32'(fill_req_valid), 1);
    rst_n = 1'b0;
    @(negedge clk);
    chk(busy === 1'b0 && fill_req_valid === 1'b0, "R1", "idle after mid-fill reset",
        32'({busy, fill_req_valid}), 0);
    rst_n = 1'b1;
    access(12'h0A7, K_M, 1, 1'b0, '0);
    access(12'h0A7, K_H, 0, 1'b0, '0);

    finished = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule